// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This controller works beside a program counter. It repeats a block of instructions a set number of times, and the program needs no branch instruction inside the loop. A loop command gives three things: the address of the first instruction after the loop body (the end label), the address of the loop instruction itself, and an iteration count. The count comes either from an immediate field or from one byte of a register operand.

After the command, the controller watches the fetch address. When the last body instruction is fetched and iterations remain, it overrides the next PC with the loop start address in the same cycle. The loop therefore adds no cycle per iteration. A count of zero skips the body.

While a loop is armed or running, an interrupt-inhibit output stays high, so the loop cannot be interrupted. A second loop command that arrives during an active loop is rejected, and the controller flags it.

Top module: `hw_loop_ctrl`

## Requirements
- R1: After reset, `busy_o`, `redirect_o`, `irq_inhibit_o` and `cmd_err_o` are low.
- R2: Setup takes one cycle. An accepted command with a count of 1 or more and a non-empty body raises `busy_o` from the next cycle onward. During the command cycle itself, `redirect_o` stays low.
- R3: The count source is chosen by `cmd_src_i`.
  - When `cmd_src_i` is 0, the count is the 9-bit immediate `cmd_imm_i`. Any value above 256 is taken as 256.
  - When `cmd_src_i` is 1, the count is the byte k of `cmd_reg_i` (bits 8k+7 down to 8k), zero-extended, where k = `cmd_byte_i`.
- R4: The loop start is `pc_i`+1 of the command cycle. While `busy_o` is high and `pc_i` equals the end address minus 1, with iterations left, `redirect_o` is 1 and `redirect_pc_o` is the loop start, both in that same cycle.
- R5: With a count N of 1 or more, the first body instruction is fetched exactly N times and N-1 redirects occur. On the final fetch of the last body instruction there is no redirect, and `busy_o` is low from the next cycle.
- R6: A count of 0 with a non-empty body drives `redirect_o`=1 and `redirect_pc_o`=end address in the command cycle. `busy_o` never rises.
- R7: An empty body (end address = `pc_i`+1) causes no redirect and no busy period, whatever the count.
- R8: `irq_inhibit_o` is high in the cycle of an accepted command with a count of 1 or more and a non-empty body, and in every busy cycle. Otherwise it is low.
- R9: A command that arrives while `busy_o` is high is ignored. The running loop keeps its iteration count and addresses, and `cmd_err_o` is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Loop command present at the current fetch |
| cmd_src_i | input | 1 | Count source: 0 immediate, 1 register byte |
| cmd_imm_i | input | 9 | Immediate iteration count |
| cmd_reg_i | input | 32 | Register operand that holds the count byte |
| cmd_byte_i | input | 2 | Byte lane of the register operand |
| cmd_end_i | input | 16 | End label: the address after the last body instruction |
| pc_i | input | 16 | Current fetch address |
| redirect_o | output | 1 | Override the next PC |
| redirect_pc_o | output | 16 | Next PC to use when redirecting |
| busy_o | output | 1 | Loop active |
| irq_inhibit_o | output | 1 | Hold off interrupts |
| cmd_err_o | output | 1 | A command was rejected in the previous cycle |

## Verification
A corrupted remaining count shows up within one pass of the body. The number of fetches of the first body instruction then differs from the requested count, and `busy_o` falls one pass early or late. A wrong stored start or end address shows up at the first fetch of the last body instruction: either an override to the wrong address, or a missing override that lets fetch run past the label. A stale busy flag shows on `irq_inhibit_o` in the first cycle after the loop.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    SRC_IMM = 1'b0,
    SRC_REG = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/hwl_count_sel.sv
module hwl_count_sel
  import hwl_pkg::*;
#(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned MAX_ITER = 256,
  parameter int unsigned CNT_W    = 9,
  parameter int unsigned SEL_W    = 2
) (
  input  logic             src_i,
  input  logic [CNT_W-1:0] imm_i,
  input  logic [REG_W-1:0] reg_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned LANES = REG_W / LANE_W;
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ITER);

  logic [LANES-1:0][LANE_W-1:0] lanes;
  logic [CNT_W-1:0] lane_cnt, raw;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = reg_i[g*LANE_W +: LANE_W];
  end

  if (CNT_W > LANE_W) begin : g_wide
    assign lane_cnt = {{(CNT_W-LANE_W){1'b0}}, lanes[sel_i]};
  end else begin : g_narrow
    assign lane_cnt = lanes[sel_i][CNT_W-1:0];
  end

  assign raw   = (cnt_src_e'(src_i) == SRC_REG) ? lane_cnt : imm_i;
  assign cnt_o = (raw > CAP) ? CAP : raw;
endmodule

// File: rtl/hwl_bounds.sv
module hwl_bounds #(
  parameter int unsigned PC_W    = 16,
  parameter int unsigned PC_STEP = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PC_W-1:0] cmd_pc_i,
  input  logic [PC_W-1:0] cmd_end_i,
  input  logic [PC_W-1:0] pc_i,
  output logic            empty_o,
  output logic            at_last_o,
  output logic [PC_W-1:0] start_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [PC_W-1:0] start_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      last_q  <= '0;
    end else if (load_i) begin
      start_q <= cmd_pc_i + STEP;
      last_q  <= cmd_end_i - STEP;
    end
  end

  assign empty_o   = (cmd_end_i == cmd_pc_i + STEP);
  assign at_last_o = (pc_i == last_q);
  assign start_o   = start_q;
endmodule

// File: rtl/hwl_iter.sv
module hwl_iter #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             at_last_i,
  output logic             busy_o,
  output logic             more_o
);
  logic [CNT_W-1:0] rem_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= cnt_i - CNT_W'(1);
      busy_q <= 1'b1;
    end else if (busy_q && at_last_i) begin
      if (rem_q != '0) rem_q <= rem_q - CNT_W'(1);
      else busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign more_o = (rem_q != '0);
endmodule

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl #(
  parameter int unsigned PC_W     = 16,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned MAX_ITER = 256,
  parameter int unsigned PC_STEP  = 1,
  localparam int unsigned CNT_W   = $clog2(MAX_ITER + 1),
  localparam int unsigned SEL_W   = $clog2(REG_W / 8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic             cmd_src_i,
  input  logic [CNT_W-1:0] cmd_imm_i,
  input  logic [REG_W-1:0] cmd_reg_i,
  input  logic [SEL_W-1:0] cmd_byte_i,
  input  logic [PC_W-1:0]  cmd_end_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic             busy_o,
  output logic             irq_inhibit_o,
  output logic             cmd_err_o
);
  logic [CNT_W-1:0] cnt;
  logic [PC_W-1:0]  start;
  logic empty, at_last, busy, more;
  logic accept, arm, skip, loop_back, err_q;

  hwl_count_sel #(
    .REG_W(REG_W), .MAX_ITER(MAX_ITER), .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_cnt (
    .src_i(cmd_src_i), .imm_i(cmd_imm_i), .reg_i(cmd_reg_i),
    .sel_i(cmd_byte_i), .cnt_o(cnt)
  );

  assign accept = cmd_valid_i && !busy;
  assign arm    = accept && !empty && (cnt != '0);
  assign skip   = accept && !empty && (cnt == '0);

  hwl_bounds #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_bounds (
    .clk_i, .rst_ni, .load_i(arm), .cmd_pc_i(pc_i), .cmd_end_i(cmd_end_i),
    .pc_i(pc_i), .empty_o(empty), .at_last_o(at_last), .start_o(start)
  );

  hwl_iter #(.CNT_W(CNT_W)) u_iter (
    .clk_i, .rst_ni, .load_i(arm), .cnt_i(cnt),
    .at_last_i(at_last), .busy_o(busy), .more_o(more)
  );

  assign loop_back = busy && at_last && more;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= cmd_valid_i && busy;
  end

  assign redirect_o    = skip || loop_back;
  assign redirect_pc_o = skip ? cmd_end_i : start;
  assign busy_o        = busy;
  assign irq_inhibit_o = busy || arm;
  assign cmd_err_o     = err_q;
endmodule

// File: rtl/hw_loop_ctrl_chk.sv
module hw_loop_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic arm,
  input logic redirect_o,
  input logic busy_o,
  input logic irq_inhibit_o,
  input logic cmd_err_o
);
  assert_busy_inhibits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> irq_inhibit_o);
  assert_reject_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o) |=> cmd_err_o);
  assert_err_only_on_reject_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && busy_o) |=> !cmd_err_o);
  assert_setup_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> busy_o);
  assert_redirect_has_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (busy_o || cmd_valid_i));
  assert_exit_without_redirect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(redirect_o));
endmodule

bind hw_loop_ctrl hw_loop_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .arm(arm),
  .redirect_o(redirect_o), .busy_o(busy_o), .irq_inhibit_o(irq_inhibit_o),
  .cmd_err_o(cmd_err_o)
);

// File: tb/hw_loop_ctrl_test.sv
module hw_loop_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_src = 1'b0;
  logic [8:0]  cmd_imm = '0;
  logic [31:0] cmd_reg = '0;
  logic [1:0]  cmd_byte = '0;
  logic [15:0] cmd_end = '0, pc = '0;
  logic redirect, busy, inhibit, err;
  logic [15:0] redirect_pc;
  int checks = 0, fails = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hw_loop_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_src_i(cmd_src),
    .cmd_imm_i(cmd_imm), .cmd_reg_i(cmd_reg), .cmd_byte_i(cmd_byte),
    .cmd_end_i(cmd_end), .pc_i(pc), .redirect_o(redirect),
    .redirect_pc_o(redirect_pc), .busy_o(busy), .irq_inhibit_o(inhibit),
    .cmd_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one loop from command to end label; inj>0 issues a rejected command at body cycle inj
  task automatic run(input int lp, input int body, input bit src, input int imm,
                     input logic [31:0] rv, input int sel, input int n, input int inj);
    int e = lp + 1 + body;
    int nxt, entries = 0, redirs = 0, bad_inh = 0, bad_busy = 0, bad_pc = 0, cyc = 0;
    bit live = (n > 0) && (body > 0);
    bit err_due = 0, err_seen = 0;
    @(negedge clk);
    pc = 16'(lp); cmd_valid = 1; cmd_src = src; cmd_imm = 9'(imm);
    cmd_reg = rv; cmd_byte = 2'(sel); cmd_end = 16'(e);
    #1;
    if (body > 0 && n == 0) begin
      chk(redirect && redirect_pc == 16'(e), "R6", int'(redirect_pc), e);
      chk(!inhibit, "R8", inhibit, 0);
      nxt = e;
    end else begin
      chk(!redirect, "R2", redirect, 0);
      chk(inhibit == live, "R8", inhibit, live);
      nxt = lp + 1;
    end
    while (nxt != e && cyc < 3000) begin
      @(negedge clk);
      cmd_valid = 0; pc = 16'(nxt); cyc++;
      if (err_due) begin err_seen = err; err_due = 0; end
      if (cyc == inj && inj > 0) begin
        cmd_valid = 1; cmd_src = 0; cmd_imm = 0; cmd_end = 16'(lp + 2);
        err_due = 1;
      end
      #1;
      if (!busy) bad_busy++;
      if (inhibit != busy) bad_inh++;
      if (nxt == lp + 1) entries++;
      if (redirect) begin
        redirs++;
        if (redirect_pc != 16'(lp + 1)) bad_pc++;
        nxt = int'(redirect_pc);
      end else nxt = nxt + 1;
    end
    @(negedge clk);
    cmd_valid = 0; pc = 16'(e);
    if (err_due) begin err_seen = err; err_due = 0; end
    #1;
    chk(bad_busy == 0, live ? "R2" : "R7", bad_busy, 0);
    chk(bad_inh == 0, "R8", bad_inh, 0);
    chk(bad_pc == 0, "R4", bad_pc, 0);
    chk(entries == (live ? n : 0), src ? "R3" : "R5", entries, live ? n : 0);
    chk(redirs == (live ? n - 1 : 0), "R5", redirs, live ? n - 1 : 0);
    chk(!busy && !inhibit, "R5", busy, 0);
    if (inj > 0) begin
      chk(err_seen, "R9", err_seen, 1);
      chk(!err, "R9", err, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !redirect && !inhibit && !err, "R1", {busy, redirect, inhibit, err}, 0);
    rst_n = 1;
    for (int n = 0; n <= 40; n++) run(100, 3, 0, n, 0, 0, n, 0);
    for (int b = 1; b <= 4; b++)
      for (int n = 0; n <= 5; n++) run(200, b, 0, n, 0, 0, n, 0);
    run(300, 2, 0, 255, 0, 0, 255, 0);
    run(300, 2, 0, 256, 0, 0, 256, 0);
    run(300, 2, 0, 300, 0, 0, 256, 0);
    run(300, 2, 0, 511, 0, 0, 256, 0);
    for (int s = 0; s < 4; s++) begin
      run(400, 3, 1, 0, 32'h07_0C_03_09, s, (32'h07_0C_03_09 >> (8*s)) & 8'hFF, 0);
      run(400, 2, 1, 200, 32'h00_00_00_00, s, 0, 0);
      run(400, 1, 1, 0, 32'hFFFF_FFFF, s, 255, 0);
    end
    run(500, 0, 0, 7, 0, 0, 7, 0);
    run(500, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 1; i <= 6; i++) run(600, 3, 0, 5, 0, 0, 5, i);
    done = 1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule